// File: doc/BRIEF.md
# SPI Digital Potentiometer Command Decoder

This block is the serial slave front end of a single digitally controlled potentiometer with 64 wiper positions. It sits between an SPI-style host bus (serial clock, data in, data out, active-low select and an active-low pause line) and the register logic that holds the wiper setting and four stored settings. The block checks a device identification byte against a strap pin and decodes an instruction byte. It then either collects a data byte from the host or returns one, and turns each accepted command into a single-cycle request towards the registers.

All bus pins are brought into the system clock domain through a synchroniser chain of `SYNC_STAGES` flops, and bus edges are found there. Host data is taken on rising serial clock edges. Readback data moves on falling edges. The output enable is gated directly by the raw select and pause pins. The block itself does not store the wiper or the data registers. It returns whatever value the register side presents on `wcr_q`, `dr_rdata` and `wip`.

Top module: `spi_pot_cmd`

## Requirements
- R1: After reset, no frame is decoded until the synchronised `cs_n` has been seen going from high to low. A frame sent while `cs_n` has been held low since reset produces no request.
- R2: The first byte of a frame (MSB first) must equal `{7'b0101110, addr_strap}`. On any mismatch the rest of the frame is ignored until `cs_n` goes high.
- R3: The second byte is `{op[3:0], sel[1:0], 2'b00}`. Valid opcodes are 1001 read wiper, 1010 write wiper, 1011 read register, 1100 write register, 1101 register-to-wiper copy and 1110 wiper-to-register copy, plus 0010 step. The whole byte 8'h51 is the status read. Any other byte, including nonzero low two bits, makes the rest of the frame ignored.
- R4: For write wiper and write register, the low 6 bits of the third byte appear on `wr_data` together with a one-cycle `wcr_load` or `dr_write`. `reg_sel` carries `sel`.
- R5: The two copy commands raise `xfer_to_wcr` or `xfer_to_dr` for one cycle once the instruction byte is complete, with `reg_sel` = `sel`, and need no third byte.
- R6: Read wiper, read register and status read return a byte on `so`, MSB first, with each bit available before the next rising serial clock edge. The byte is `{2'b00, value}` for the two reads and `{7'b0, wip}` for status. `so` changes only after a falling serial clock edge.
- R7: After the step opcode, every rising serial clock edge gives one `wiper_inc` pulse if `si` is 1, or one `wiper_dec` pulse if `si` is 0, until `cs_n` rises.
- R8: If `cs_n` rises before all 8 bits of a write's data byte have been received, no write request is issued.
- R9: While `hold_n` is low, serial clock edges are ignored and the bit position is kept, so the frame continues correctly once `hold_n` returns high.
- R10: `so_oe` is 0 whenever `cs_n` is high or `hold_n` is low, and it is 1 during the data byte of a read command.
- R11: Every request output is a single system-clock pulse, at most one request is active in any cycle, and none is active after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low device select |
| hold_n | input | 1 | Active-low bus pause |
| addr_strap | input | 1 | Device address strap, compared with ID byte bit 0 |
| wip | input | 1 | Write-in-progress flag returned by status read |
| wcr_q | input | 6 | Current wiper value for readback |
| dr_rdata | input | 6 | Value of the data register chosen by `reg_sel` |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for `so` (tri-state control) |
| reg_sel | output | 2 | Data register index of the current command |
| wr_data | output | 6 | Value for wiper or register writes |
| wcr_load | output | 1 | Load wiper from `wr_data` |
| dr_write | output | 1 | Write `wr_data` into register `reg_sel` |
| xfer_to_wcr | output | 1 | Copy register `reg_sel` into the wiper |
| xfer_to_dr | output | 1 | Copy the wiper into register `reg_sel` |
| wiper_inc | output | 1 | Step wiper one position up |
| wiper_dec | output | 1 | Step wiper one position down |

## Verification
The bench holds `cs_n` low through reset and sends a full frame. A decoder that treated the level as a select, instead of waiting for an edge, would load the wiper there. It also sends frames with a wrong strap bit or device type, a reserved opcode and nonzero padding bits. These catch a decoder that checks only part of a byte and goes on to issue requests. A write cut short after four data bits catches a design that commits partial data. A pause in the middle of both a write and a read, with serial clock toggling during the pause, catches a design that keeps counting bits or drives the output while paused. Step sequences and random read/write traffic compare every returned byte and every request against values the bench tracks itself.

// File: rtl/spi_pot_cmd.sv
module spi_pot_cmd #(
  parameter int         SYNC_STAGES = 2,
  parameter int         VAL_W       = 6,
  parameter logic [6:0] DEV_ID      = 7'b0101110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             si,
  input  logic             cs_n,
  input  logic             hold_n,
  input  logic             addr_strap,
  input  logic             wip,
  input  logic [VAL_W-1:0] wcr_q,
  input  logic [VAL_W-1:0] dr_rdata,
  output logic             so,
  output logic             so_oe,
  output logic [1:0]       reg_sel,
  output logic [VAL_W-1:0] wr_data,
  output logic             wcr_load,
  output logic             dr_write,
  output logic             xfer_to_wcr,
  output logic             xfer_to_dr,
  output logic             wiper_inc,
  output logic             wiper_dec
);
  localparam int PAD = 8 - VAL_W;
  localparam int TOP = SYNC_STAGES - 1;

  typedef enum logic [2:0] {S_IDLE, S_ID, S_INS, S_WR, S_RD, S_STEP, S_DONE} state_t;
  typedef enum logic [1:0] {SRC_WCR, SRC_DR, SRC_STAT} src_t;

  logic [TOP:0] sck_q, si_q, cs_q, hold_q;
  logic         sck_d, cs_d;
  logic         sck_s, si_s, cs_s, hold_s;
  logic         sck_rise, sck_fall, cs_fall;

  state_t     state;
  src_t       rd_src;
  logic       wr_dr, tx_act, need_ld;
  logic [2:0] cnt;
  logic [6:0] sh;
  logic [7:0] tx, byte_in, rd_val;
  logic       last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      si_q   <= '0;
      cs_q   <= '0;
      hold_q <= '1;
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
    end else begin
      sck_q  <= {sck_q[TOP-1:0], sck};
      si_q   <= {si_q[TOP-1:0], si};
      cs_q   <= {cs_q[TOP-1:0], cs_n};
      hold_q <= {hold_q[TOP-1:0], hold_n};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end

  assign sck_s    = sck_q[TOP];
  assign si_s     = si_q[TOP];
  assign cs_s     = cs_q[TOP];
  assign hold_s   = hold_q[TOP];
  assign cs_fall  = cs_d & ~cs_s;
  assign sck_rise = hold_s & ~cs_s & sck_s & ~sck_d;
  assign sck_fall = hold_s & ~cs_s & ~sck_s & sck_d;
  assign byte_in  = {sh, si_s};
  assign last     = (cnt == 3'd7);

  always_comb
    case (rd_src)
      SRC_WCR: rd_val = {{PAD{1'b0}}, wcr_q};
      SRC_DR:  rd_val = {{PAD{1'b0}}, dr_rdata};
      default: rd_val = {7'b0, wip};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      rd_src      <= SRC_WCR;
      wr_dr       <= 1'b0;
      tx_act      <= 1'b0;
      need_ld     <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      reg_sel     <= '0;
      wr_data     <= '0;
      wcr_load    <= 1'b0;
      dr_write    <= 1'b0;
      xfer_to_wcr <= 1'b0;
      xfer_to_dr  <= 1'b0;
      wiper_inc   <= 1'b0;
      wiper_dec   <= 1'b0;
    end else begin
      wcr_load    <= 1'b0;
      dr_write    <= 1'b0;
      xfer_to_wcr <= 1'b0;
      xfer_to_dr  <= 1'b0;
      wiper_inc   <= 1'b0;
      wiper_dec   <= 1'b0;
      if (cs_s) begin
        state  <= S_IDLE;
        tx_act <= 1'b0;
      end else if (cs_fall) begin
        state <= S_ID;
        cnt   <= '0;
      end else if (sck_rise) begin
        sh  <= byte_in[6:0];
        cnt <= cnt + 3'd1;
        case (state)
          S_ID: if (last) state <= (byte_in == {DEV_ID, addr_strap}) ? S_INS : S_DONE;
          S_INS: if (last) begin
            reg_sel <= byte_in[3:2];
            state   <= S_DONE;
            if (byte_in == 8'h51) begin
              rd_src <= SRC_STAT; state <= S_RD; tx_act <= 1'b1; need_ld <= 1'b1;
            end else if (byte_in[1:0] == 2'b00) begin
              case (byte_in[7:4])
                4'h9: begin rd_src <= SRC_WCR; state <= S_RD; tx_act <= 1'b1; need_ld <= 1'b1; end
                4'hB: begin rd_src <= SRC_DR;  state <= S_RD; tx_act <= 1'b1; need_ld <= 1'b1; end
                4'hA: begin wr_dr <= 1'b0; state <= S_WR; end
                4'hC: begin wr_dr <= 1'b1; state <= S_WR; end
                4'hD: xfer_to_wcr <= 1'b1;
                4'hE: xfer_to_dr  <= 1'b1;
                4'h2: state <= S_STEP;
                default: ;
              endcase
            end
          end
          S_WR: if (last) begin
            wr_data  <= byte_in[VAL_W-1:0];
            dr_write <= wr_dr;
            wcr_load <= ~wr_dr;
            state    <= S_DONE;
          end
          S_RD: if (last) state <= S_DONE;
          S_STEP: begin
            wiper_inc <= si_s;
            wiper_dec <= ~si_s;
          end
          default: ;
        endcase
      end else if (sck_fall && tx_act) begin
        need_ld <= 1'b0;
        tx      <= need_ld ? rd_val : {tx[6:0], 1'b0};
      end
    end

  assign so    = tx[7];
  assign so_oe = tx_act & ~cs_n & hold_n;
endmodule

// File: rtl/spi_pot_cmd_chk.sv
module spi_pot_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic so,
  input logic so_oe,
  input logic sck_rise,
  input logic sck_fall,
  input logic wcr_load,
  input logic dr_write,
  input logic xfer_to_wcr,
  input logic xfer_to_dr,
  input logic wiper_inc,
  input logic wiper_dec
);
  logic any_req;
  assign any_req = wcr_load | dr_write | xfer_to_wcr | xfer_to_dr | wiper_inc | wiper_dec;

  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wcr_load, dr_write, xfer_to_wcr, xfer_to_dr, wiper_inc, wiper_dec}));

  // R11
  wcr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) wcr_load |=> !wcr_load);

  // R11
  dr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) dr_write |=> !dr_write);

  // R7
  step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_inc || wiper_dec) |=> !(wiper_inc || wiper_dec));

  // R4
  req_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) any_req |-> $past(sck_rise));

  // R6
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && (so != $past(so))) |-> $past(sck_fall));
endmodule

bind spi_pot_cmd spi_pot_cmd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_oe(so_oe),
  .sck_rise(sck_rise), .sck_fall(sck_fall),
  .wcr_load(wcr_load), .dr_write(dr_write),
  .xfer_to_wcr(xfer_to_wcr), .xfer_to_dr(xfer_to_dr),
  .wiper_inc(wiper_inc), .wiper_dec(wiper_dec)
);

// File: tb/test_spi_pot_cmd.sv
module test_spi_pot_cmd;
  localparam int HALF = 10;
  logic clk = 0, rst_n = 0;
  logic sck = 0, si = 0, cs_n = 0, hold_n = 1, addr_strap = 1, wip = 0;
  logic [5:0] wcr_q, dr_rdata, wr_data;
  logic so, so_oe, wcr_load, dr_write, xfer_to_wcr, xfer_to_dr, wiper_inc, wiper_dec;
  logic [1:0] reg_sel;

  logic [5:0] wcr_m = 0;
  logic [5:0] dr_m [4] = '{default: 0};
  logic [5:0] e_wcr;
  logic [5:0] e_dr [4];
  int n_wl = 0, n_dw = 0, n_xw = 0, n_xd = 0, n_inc = 0, n_dec = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign wcr_q    = wcr_m;
  assign dr_rdata = dr_m[reg_sel];

  spi_pot_cmd i_spi_pot_cmd (.*);

  always @(negedge clk) begin
    if (wcr_load)    begin n_wl++;  wcr_m <= wr_data; end
    if (dr_write)    begin n_dw++;  dr_m[reg_sel] <= wr_data; end
    if (xfer_to_wcr) begin n_xw++;  wcr_m <= dr_m[reg_sel]; end
    if (xfer_to_dr)  begin n_xd++;  dr_m[reg_sel] <= wcr_m; end
    if (wiper_inc)   begin n_inc++; if (wcr_m != 6'd63) wcr_m <= wcr_m + 6'd1; end
    if (wiper_dec)   begin n_dec++; if (wcr_m != 6'd0)  wcr_m <= wcr_m - 6'd1; end
  end

  function automatic int all_req();
    return n_wl + n_dw + n_xw + n_xd + n_inc + n_dec;
  endfunction
  function automatic logic [7:0] id_byte(logic a);
    return {7'b0101110, a};
  endfunction
  function automatic logic [7:0] ins_byte(logic [3:0] op, logic [1:0] sel);
    return {op, sel, 2'b00};
  endfunction
  function automatic logic [7:0] rd_byte(logic [5:0] v);
    return {2'b00, v};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    si = b; wait_clk(HALF); r = so; sck = 1; wait_clk(HALF); sck = 0;
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    logic t;
    for (int i = 7; i >= 0; i--) begin bit_io(b[i], t); r[i] = t; end
  endtask

  task automatic begin_frame(); cs_n = 0; wait_clk(4); endtask
  task automatic end_frame();   wait_clk(4); cs_n = 1; wait_clk(8); endtask

  task automatic cmd(input logic [7:0] ins, input bit three, input logic [7:0] d, output logic [7:0] r);
    logic [7:0] t;
    r = 'x;
    begin_frame();
    xbyte(id_byte(addr_strap), t);
    xbyte(ins, t);
    if (three) xbyte(d, r);
    end_frame();
  endtask

  task automatic wr_wcr(logic [5:0] v);
    logic [7:0] r; cmd(ins_byte(4'hA, 2'd0), 1, {2'b00, v}, r); e_wcr = v;
  endtask
  task automatic wr_dr(logic [1:0] s, logic [5:0] v);
    logic [7:0] r; cmd(ins_byte(4'hC, s), 1, {2'b00, v}, r); e_dr[s] = v;
  endtask
  task automatic rd(input logic [7:0] ins, output logic [7:0] r);
    cmd(ins, 1, 8'h00, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, t;
    int b0, i0, d0;
    void'($urandom(32'h1f3a));
    wait_clk(10); rst_n = 1; wait_clk(10);
    check("R11 reset no requests", all_req(), 0);
    check("R10 reset so_oe", so_oe, 0);

    // R1: cs_n held low since reset, never fell
    xbyte(id_byte(addr_strap), t); xbyte(ins_byte(4'hA, 0), t); xbyte(8'h2A, t);
    wait_clk(4); cs_n = 1; wait_clk(8);
    check("R1 no request without cs fall", n_wl, 0);

    wr_wcr(6'h15);
    check("R4 wcr_load count", n_wl, 1);
    check("R4 wr_data", wr_data, 6'h15);

    // R2
    b0 = all_req();
    cmd(ins_byte(4'hA, 0), 1, 8'h3F, r);
    cmd(ins_byte(4'hA, 0), 1, 8'h3F, r);
    begin_frame(); xbyte(id_byte(~addr_strap), t); xbyte(ins_byte(4'hA, 0), t); xbyte(8'h01, t); end_frame();
    begin_frame(); xbyte({7'b0100110, addr_strap}, t); xbyte(ins_byte(4'hD, 1), t); end_frame();
    check("R2 good id frames", all_req() - b0, 2);
    check("R2 bad id ignored wcr", wcr_m, 6'h3F);

    // R3
    b0 = all_req();
    cmd(8'h00, 1, 8'hFF, r);
    cmd(8'hA1, 1, 8'h07, r);
    cmd(8'hF4, 1, 8'hFF, r);
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(8'h22, t); xbyte(8'hFF, t); end_frame();
    check("R3 unknown/bad padding ignored", all_req() - b0, 0);

    // R5
    wr_dr(2, 6'h33);
    check("R4 dr_write reg_sel", reg_sel, 2);
    wr_wcr(6'h05);
    cmd(ins_byte(4'hD, 2), 0, 0, r);
    check("R5 xfer_to_wcr count", n_xw, 1);
    rd(ins_byte(4'h9, 0), r);
    check("R5/R6 wcr after copy", r, rd_byte(6'h33));
    cmd(ins_byte(4'hE, 1), 0, 0, r);
    check("R5 xfer_to_dr reg_sel", reg_sel, 1);
    rd(ins_byte(4'hB, 1), r);
    check("R5/R6 dr1 after copy", r, rd_byte(6'h33));

    // R6 status and R10 enable
    wip = 1;
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(8'h51, t); xbyte(8'h00, r);
    check("R10 so_oe in read", so_oe, 1);
    end_frame();
    check("R6 status wip=1", r, 8'h01);
    check("R10 so_oe after cs high", so_oe, 0);
    wip = 0; rd(8'h51, r);
    check("R6 status wip=0", r, 8'h00);

    // R7
    wr_wcr(6'h20);
    i0 = n_inc; d0 = n_dec; b0 = 0;
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(ins_byte(4'h2, 0), t);
    for (int k = 0; k < 20; k++) begin
      logic s; s = $urandom_range(0, 1); b0 += s ? 1 : -1; bit_io(s, t);
    end
    end_frame();
    check("R7 inc+dec pulses", (n_inc - i0) + (n_dec - d0), 20);
    check("R7 net steps", (n_inc - i0) - (n_dec - d0), b0);
    rd(ins_byte(4'h9, 0), r);
    check("R7 wiper after steps", r, rd_byte(6'(32 + b0)));

    // R8
    b0 = all_req();
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(ins_byte(4'hA, 0), t);
    for (int k = 0; k < 4; k++) bit_io(1'b1, t);
    end_frame();
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(ins_byte(4'hC, 3), t);
    for (int k = 0; k < 7; k++) bit_io(1'b1, t);
    end_frame();
    check("R8 truncated writes dropped", all_req() - b0, 0);

    // R9 hold during write
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(ins_byte(4'hA, 0), t);
    bit_io(0, t); bit_io(0, t); bit_io(1, t);
    wait_clk(4); hold_n = 0; wait_clk(6);
    for (int k = 0; k < 3; k++) begin si = ~si; sck = 1; wait_clk(HALF); sck = 0; wait_clk(HALF); end
    hold_n = 1; wait_clk(6);
    bit_io(0, t); bit_io(1, t); bit_io(1, t); bit_io(0, t); bit_io(0, t);
    end_frame();
    check("R9 write across hold", wcr_m, 6'h2C);
    e_wcr = 6'h2C;

    // R9/R10 hold during read
    wr_dr(0, 6'h2D);
    begin_frame(); xbyte(id_byte(addr_strap), t); xbyte(ins_byte(4'hB, 0), t);
    for (int k = 7; k >= 5; k--) begin bit_io(0, t); r[k] = t; end
    wait_clk(4); hold_n = 0; wait_clk(6);
    check("R10 so_oe low in hold", so_oe, 0);
    for (int k = 0; k < 2; k++) begin sck = 1; wait_clk(HALF); sck = 0; wait_clk(HALF); end
    hold_n = 1; wait_clk(6);
    for (int k = 4; k >= 0; k--) begin bit_io(0, t); r[k] = t; end
    end_frame();
    check("R9 read across hold", r, rd_byte(6'h2D));

    // random traffic
    for (int s = 0; s < 4; s++) wr_dr(2'(s), 6'($urandom_range(0, 63)));
    wr_wcr(6'($urandom_range(0, 63)));
    for (int n = 0; n < 40; n++) begin
      int op; logic [1:0] sl; logic [5:0] v;
      op = $urandom_range(0, 3); sl = 2'($urandom_range(0, 3)); v = 6'($urandom_range(0, 63));
      case (op)
        0: wr_wcr(v);
        1: wr_dr(sl, v);
        2: begin rd(ins_byte(4'h9, 0), r); check("R6 random wcr read", r, rd_byte(e_wcr)); end
        default: begin rd(ins_byte(4'hB, sl), r); check("R6 random dr read", r, rd_byte(e_dr[sl])); end
      endcase
    end
    check("R11 no stray copies", n_xw + n_xd, 2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule